// File: doc/BRIEF.md
# Programmable Fractional Clock Divider

This block derives a slower rate from a base clock at a rational ratio n/m, with n no larger than m. It does not count to an integer limit. A signed accumulator is stepped down by a negative "subtract" step each cycle. Whenever that would take it below zero, it is stepped by an "add" step instead and a wrap is recorded. Over any m consecutive running cycles there are exactly n wraps.

The output is either a one-cycle enable per wrap, or a stretched clock whose high phase covers about half of each output period. A gating option drives a domain clock that is the base clock with its high phases kept only in cycles after a wrap. Software programs all of this through a single 24-bit configuration word.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst_i` is high, `div_o` and `gclk_o` stay low and the configuration word is cleared, so run, clear, stretch and gating are all off.
- R2: When `cfg_wr_i` is high at a rising edge, the word on `cfg_wdata_i` is captured. Bit 0 is run, bit 1 is clear, bit 2 is stretch and bit 4 is gate. Bits [15:8] hold the signed subtract step and bits [23:16] hold the unsigned add step. A new word steers the datapath from the following edge.
- R3: On each running edge the accumulator takes acc+sub. If that sum is negative, it takes acc+add instead and the edge counts as a wrap. For a ratio n/m the steps are sub = -16n and add = 16(m-n).
- R4: With stretch off, `div_o` is high for exactly one cycle after each wrap. Any m consecutive running cycles hold exactly n pulses. Three checked examples: sub 0xB0 with add 0x70 gives 5/12, sub 0xF0 with add 0x90 gives 1/10, and sub 0xC0 with add 0x40 gives 1/2.
- R5: While clear is set, the accumulator is forced to zero and `div_o` is low, whatever run holds.
- R6: While run is low and clear is low, `div_o` is low and the accumulator holds its value. On resume the sequence continues from where it stopped.
- R7: With stretch on, `div_o` is high in the cycle after an edge exactly when the updated accumulator is at least floor(span/2), where span = add - sub. Ratios 1/2 and 1/10 give a 50% duty cycle.
- R8: With gate off and reset low, `gclk_o` follows the base clock in every cycle.
- R9: With gate on, `gclk_o` keeps the high phase of a base cycle only when the one-cycle wrap enable was high in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | 24 | Configuration word (control, subtract step, add step) |
| div_o | output | 1 | Wrap enable pulse, or stretched clock when stretch is set |
| gclk_o | output | 1 | Gated domain clock |

## Verification
The hardest state to reach is a ratio change in mid-sequence, or a run pause at an arbitrary accumulator value. In that state the wrap pattern depends on history, not only on n and m. Random stimulus therefore rewrites the configuration word at random cycles, toggling run, clear, stretch and gate at random and picking a random legal n and m. A bench model follows the accumulator through each change. Directed windows then settle the three named ratios and count pulses and high cycles over exactly m cycles.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    localparam int FW    = 8;          // step field width
    localparam int CFG_W = 8 + 2 * FW; // configuration word width
    localparam int ACC_W = FW + 3;     // accumulator width, holds acc+add

    // control bit positions in the low byte
    localparam int B_RUN     = 0;
    localparam int B_CLR     = 1;
    localparam int B_STRETCH = 2;
    localparam int B_GATE    = 4;
    localparam int SUB_LSB   = 8;
    localparam int ADD_LSB   = 8 + FW;

    typedef struct packed {
        logic [FW-1:0]        add_step;
        logic signed [FW-1:0] sub_step;
        logic                 gate;
        logic                 stretch;
        logic                 clr;
        logic                 run;
    } cfg_t;

    typedef logic signed [ACC_W-1:0] acc_t;

    function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        cfg_t c;
        c.add_step = w[ADD_LSB +: FW];
        c.sub_step = w[SUB_LSB +: FW];
        c.gate     = w[B_GATE];
        c.stretch  = w[B_STRETCH];
        c.clr      = w[B_CLR];
        c.run      = w[B_RUN];
        return c;
    endfunction

    function automatic acc_t sext_step(input logic signed [FW-1:0] s);
        return {{(ACC_W-FW){s[FW-1]}}, s};
    endfunction

    function automatic acc_t zext_step(input logic [FW-1:0] s);
        return {{(ACC_W-FW){1'b0}}, s};
    endfunction
endpackage

// File: rtl/fd_cfg_reg.sv
module fd_cfg_reg
    import fdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    output cfg_t             cfg_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i)
            cfg_o <= '0;
        else if (wr_i)
            cfg_o <= decode_cfg(wdata_i);
    end

    // R1: the word is empty on the first cycle after reset
    p_cfg_reset_r1: assert property (@(posedge clk_i)
        $past(rst_i) && !rst_i |-> cfg_o == '0);
endmodule

// File: rtl/fd_accum.sv
module fd_accum
    import fdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  cfg_t cfg_i,
    output logic div_o,
    output logic en_o
);
    acc_t acc_q;
    acc_t sub_w, add_w, sum_w, nxt_w, span_w, half_w;
    logic wrap_w;

    always_comb begin
        sub_w  = sext_step(cfg_i.sub_step);
        add_w  = zext_step(cfg_i.add_step);
        sum_w  = acc_q + sub_w;
        wrap_w = sum_w[ACC_W-1];
        nxt_w  = wrap_w ? acc_q + add_w : sum_w;
        span_w = add_w - sub_w;
        half_w = span_w >>> 1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || cfg_i.clr) begin
            acc_q <= '0;
            en_o  <= 1'b0;
            div_o <= 1'b0;
        end else if (cfg_i.run) begin
            acc_q <= nxt_w;
            en_o  <= wrap_w;
            div_o <= cfg_i.stretch ? (nxt_w >= half_w) : wrap_w;
        end else begin
            en_o  <= 1'b0;
            div_o <= 1'b0;
        end
    end

    p_acc_nonneg_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !acc_q[ACC_W-1]);
    p_clear_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        cfg_i.clr |=> (acc_q == '0) && !div_o && !en_o);
    p_idle_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cfg_i.run && !cfg_i.clr) |=> $stable(acc_q) && !div_o);
    p_pulse_mode_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_i.run && !cfg_i.clr && !cfg_i.stretch) |=> div_o == en_o);
endmodule

// File: rtl/fd_gate.sv
module fd_gate (
    input  logic clk_i,
    input  logic rst_i,
    input  logic gate_on_i,
    input  logic en_i,
    output logic gclk_o
);
    logic keep_q;

    // captured on the falling edge so the next high phase is glitch free
    always_ff @(negedge clk_i) begin
        if (rst_i)
            keep_q <= 1'b0;
        else
            keep_q <= gate_on_i ? en_i : 1'b1;
    end

    assign gclk_o = clk_i & keep_q;

    p_free_run_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !gate_on_i |-> keep_q);
    p_gated_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        gate_on_i |-> keep_q == en_i);
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import fdiv_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             div_o,
    output logic             gclk_o
);
    cfg_t cfg_q;
    logic en_w;

    fd_cfg_reg u_cfg (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_i    (cfg_wr_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg_q)
    );

    fd_accum u_acc (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .cfg_i (cfg_q),
        .div_o (div_o),
        .en_o  (en_w)
    );

    fd_gate u_gate (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .gate_on_i (cfg_q.gate),
        .en_i      (en_w),
        .gclk_o    (gclk_o)
    );

    p_reset_quiet_r1: assert property (@(posedge clk_i)
        $past(rst_i) |-> !div_o);
endmodule

// File: tb/tb_frac_clk_div.sv
module tb_frac_clk_div;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr;
    logic [23:0] wdata;
    logic        div_o, gclk_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // bench model state
    bit m_run, m_clr, m_str, m_gate;
    int m_sub, m_add, m_acc;
    bit m_en, m_div, m_gk;

    always #5 clk = ~clk;

    frac_clk_div dut (
        .clk_i(clk), .rst_i(rst), .cfg_wr_i(wr), .cfg_wdata_i(wdata),
        .div_o(div_o), .gclk_o(gclk_o)
    );

    function automatic logic [23:0] mk(input int n, input int m, input bit run,
                                       input bit clr, input bit str, input bit gate);
        logic [7:0] s, a;
        s = 8'(-16 * n);
        a = 8'(16 * (m - n));
        return {a, s, 3'b000, gate, 1'b0, str, clr, run};
    endfunction

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    task automatic model_edge();
        int sum, nxt, span;
        bit wrap;
        m_gk = rst ? 1'b0 : (m_gate ? m_en : 1'b1);
        if (rst) begin
            m_run = 0; m_clr = 0; m_str = 0; m_gate = 0;
            m_sub = 0; m_add = 0; m_acc = 0; m_en = 0; m_div = 0;
        end else begin
            if (m_clr) begin
                m_acc = 0; m_en = 0; m_div = 0;
            end else if (m_run) begin
                sum  = m_acc + m_sub;
                wrap = sum < 0;
                nxt  = wrap ? m_acc + m_add : sum;
                span = m_add - m_sub;
                m_acc = nxt;
                m_en  = wrap;
                m_div = m_str ? (nxt >= span / 2) : wrap;
            end else begin
                m_en = 0; m_div = 0;
            end
            if (wr) begin
                m_run  = wdata[0];
                m_clr  = wdata[1];
                m_str  = wdata[2];
                m_gate = wdata[4];
                m_sub  = int'($signed(wdata[15:8]));
                m_add  = int'(wdata[23:16]);
            end
        end
    endtask

    // one clock edge; model follows, outputs compared in the high phase
    task automatic step();
        @(posedge clk);
        model_edge();
        cyc++;
        #2;
        chk(div_o == m_div, m_str ? "R7" : (m_run ? "R4/R3" : "R6"), div_o, m_div);
        chk(gclk_o == m_gk, m_gate ? "R9" : "R8", gclk_o, m_gk);
    endtask

    task automatic write(input logic [23:0] w);
        wr = 1'b1; wdata = w;
        step();
        wr = 1'b0;
    endtask

    task automatic ratio_window(input int n, input int m, input bit str);
        int cnt;
        write(mk(n, m, 0, 1, str, 0));
        write(mk(n, m, 1, 0, str, 0));
        repeat (2 * m) step();
        cnt = 0;
        for (int i = 0; i < m; i++) begin
            step();
            if (div_o) cnt++;
        end
        if (str)
            chk(cnt == m / 2, "R7 duty", cnt, m / 2);
        else
            chk(cnt == n, "R4 count", cnt, n);
    endtask

    initial begin : watchdog
        #1900000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, m;
        logic [23:0] w;
        void'($urandom(32'd4321));
        rst = 1'b1; wr = 1'b0; wdata = '0;
        repeat (3) step();
        chk(div_o == 1'b0, "R1 div", div_o, 0);
        chk(gclk_o == 1'b0, "R1 gclk", gclk_o, 0);
        // write during reset must not stick
        wr = 1'b1; wdata = mk(1, 2, 1, 0, 0, 1);
        step();
        wr = 1'b0; rst = 1'b0;
        repeat (3) step();
        chk(div_o == 1'b0, "R1 cfg cleared", div_o, 0);

        // R2: a word captured at one edge acts from the next edge
        write(mk(4, 8, 1, 0, 0, 0));
        chk(div_o == 1'b0, "R2 latency", div_o, 0);
        step();
        chk(div_o == 1'b1, "R2 first wrap", div_o, 1);

        // R4: named ratios, 5/12, 1/10, 1/2
        ratio_window(5, 12, 0);
        ratio_window(1, 10, 0);
        ratio_window(4, 8, 0);
        ratio_window(3, 3, 0);
        // R7: stretched duty
        ratio_window(1, 10, 1);
        ratio_window(4, 8, 1);

        // R5: clear beats run
        write(mk(5, 12, 1, 1, 0, 0));
        for (int i = 0; i < 4; i++) begin
            step();
            chk(div_o == 1'b0, "R5 clear", div_o, 0);
        end

        // R6: pause in mid-sequence then resume
        write(mk(5, 12, 1, 0, 0, 0));
        repeat (7) step();
        write(mk(5, 12, 0, 0, 0, 0));
        for (int i = 0; i < 5; i++) begin
            step();
            chk(div_o == 1'b0, "R6 paused", div_o, 0);
        end
        write(mk(5, 12, 1, 0, 0, 0));
        repeat (24) step();

        // R9: gated domain clock at 1/10
        write(mk(1, 10, 1, 0, 0, 1));
        repeat (30) step();

        // random configuration changes
        for (int it = 0; it < 6000; it++) begin
            if ($urandom_range(0, 19) == 0) begin
                n = $urandom_range(1, 8);
                m = n + $urandom_range(0, 15);
                w = mk(n, m, $urandom_range(0, 5) != 0, $urandom_range(0, 7) == 0,
                       $urandom_range(0, 1), $urandom_range(0, 1));
                write(w);
            end else begin
                step();
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule